// File: doc/BRIEF.md
# Acquisition Status and Interrupt Routing Registers

This block holds a pair of 8-bit registers that a host reaches over a simple register bus in a data-acquisition controller. The lower register is read-only status: it mirrors converter busy, amplifier range, input multiplexer mode and the current channel number. It also shows a sticky flag that records a rising edge seen on an external trigger pin. The upper register is read/write control: it holds a trigger-source select, a DMA request enable, a 3-bit interrupt level code and an interrupt enable.

The trigger pin is sampled through a synchronizer, and each rising edge sets a latch. Any write to the status offset clears that latch. When interrupts are enabled, the latch drives exactly one request line, chosen by the level code. Only lines 2 to 7 can ever be driven. A DMA request from the converter side reaches the host only while the DMA enable bit is set. Reads are combinational from the current address; offsets other than the two registers read as zero.

Top module: `acq_regs_top`

## Requirements
- R1: A read at offset 8 returns convBusy in bit 7, rangeUni in bit 6, muxSingle in bit 5, the trigger flag in bit 4 and chanNum in bits 3:0 (bit 0 has weight 1).
- R2: A write at offset 9 stores the data. A read at offset 9 returns it with bit 3 forced to 0. Bits 1:0 are the trigger source (driven on trigSel), bit 2 is the DMA enable, bits 6:4 are the level code (bit 4 has weight 1) and bit 7 is the interrupt enable.
- R3: After reset, the control register reads 0x00, the trigger flag is 0 and no request line is asserted.
- R4: A trigger pulse high for 25 clock cycles (200 ns at 125 MHz) sets the flag within 4 cycles of its rising edge. The flag then stays set after the pin falls.
- R5: A write of any data to offset 8 clears the trigger flag.
- R6: With the interrupt enable at 1 and the flag set, irqReq[k] is 1 for level code k in 2..7, and every other line is 0.
- R7: Level codes 0 and 1 never assert any request line, and irqReq[1:0] is always 0.
- R8: With the interrupt enable at 0, all request lines are 0 whatever the flag.
- R9: dmaReqOut equals dmaReqIn while the DMA enable is 1, and stays 0 while it is 0.
- R10: If a trigger rising edge and a clearing write land in the same cycle, the flag ends set.
- R11: The flag is set only by a rising edge. A pin held high through a clearing write does not set it again.
- R12: Reads at offsets other than 8 and 9 return 0. Writes there leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the current offset |
| convBusy | input | 1 | Converter busy |
| rangeUni | input | 1 | 1 = unipolar range |
| muxSingle | input | 1 | 1 = 16 single-ended, 0 = 8 differential |
| chanNum | input | 4 | Current channel number |
| trigPin | input | 1 | External trigger, asynchronous |
| dmaReqIn | input | 1 | DMA request from the converter side |
| dmaReqOut | output | 1 | Gated DMA request to the host |
| trigSel | output | 2 | Selected conversion trigger source |
| irqReq | output | 8 | One-hot interrupt request lines, bit k is line k |

## Verification
The bench walks all eight level codes with the interrupt enable on and off. A wrong decoder would light line 0 or 1, or light a line while disabled. It times a clearing write to land in the cycle the trigger edge is detected. A design that gave the clear priority would drop that event and read bit 4 as 0. It also holds the pin high through a clear: a level-sensitive latch would set again at once and keep the interrupt asserted. Reserved bit 3, stray offsets and the DMA gate are checked at the read port and the request outputs.

// File: rtl/acq_regs_pkg.sv
package acq_regs_pkg;
  typedef struct packed {
    logic clrTrig;
    logic wrCtrl;
  } acqStrobe_t;

  localparam int CTRL_RSVD_BIT = 3;
  localparam int CTRL_DMA_BIT  = 2;
  localparam int CTRL_INTE_BIT = 7;
  localparam int CTRL_LVL_LSB  = 4;
endpackage

// File: rtl/acq_regs_ctrl.sv
module acq_regs_ctrl
  import acq_regs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output acqStrobe_t        strb,
  output logic              selStat,
  output logic              selCtrl
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(STAT_OFS + 1);

  always_comb begin
    selStat      = (busAddr == STAT_A);
    selCtrl      = (busAddr == CTRL_A);
    strb.clrTrig = busSel && busWr && selStat;
    strb.wrCtrl  = busSel && busWr && selCtrl;
  end
endmodule

// File: rtl/acq_regs_dp.sv
module acq_regs_dp
  import acq_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CHAN_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_LINES   = 8,
  parameter int MIN_LEVEL   = 2,
  parameter int LVL_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  acqStrobe_t        strb,
  input  logic              selStat,
  input  logic              selCtrl,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              convBusy,
  input  logic              rangeUni,
  input  logic              muxSingle,
  input  logic [CHAN_W-1:0] chanNum,
  input  logic              trigPin,
  input  logic              dmaReqIn,
  output logic              dmaReqOut,
  output logic [1:0]        trigSel,
  output logic [IRQ_LINES-1:0] irqReq,
  output logic              trigLatch,
  output logic              trigRise,
  output logic [DATA_W-1:0] ctrlQ
);
  localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'(1) << CTRL_RSVD_BIT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   trigPrev;
  logic [LVL_W-1:0]       level;
  logic                   irqActive;
  logic [DATA_W-1:0]      statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigPin};
      trigPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign trigRise = syncQ[SYNC_STAGES-1] & ~trigPrev;

  // a new edge wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             trigLatch <= 1'b0;
    else if (trigRise)     trigLatch <= 1'b1;
    else if (strb.clrTrig) trigLatch <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlQ <= '0;
    else if (strb.wrCtrl) ctrlQ <= busWdata & RSVD_MASK;
  end

  assign level     = ctrlQ[CTRL_LVL_LSB +: LVL_W];
  assign irqActive = trigLatch & ctrlQ[CTRL_INTE_BIT];
  assign trigSel   = ctrlQ[1:0];
  assign dmaReqOut = dmaReqIn & ctrlQ[CTRL_DMA_BIT];

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_irq
    if (g < MIN_LEVEL) begin : g_never
      assign irqReq[g] = 1'b0;
    end else begin : g_line
      assign irqReq[g] = irqActive && (level == LVL_W'(g));
    end
  end

  assign statusWord = {convBusy, rangeUni, muxSingle, trigLatch, chanNum};

  always_comb begin
    if (selStat)      busRdata = statusWord;
    else if (selCtrl) busRdata = ctrlQ;
    else              busRdata = '0;
  end
endmodule

// File: rtl/acq_regs_top.sv
module acq_regs_top
  import acq_regs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              convBusy,
  input  logic              rangeUni,
  input  logic              muxSingle,
  input  logic [3:0]        chanNum,
  input  logic              trigPin,
  input  logic              dmaReqIn,
  output logic              dmaReqOut,
  output logic [1:0]        trigSel,
  output logic [7:0]        irqReq
);
  acqStrobe_t strb;
  logic       selStat, selCtrl;
  logic       trigLatch, trigRise;
  logic [7:0] ctrlQ;

  acq_regs_ctrl #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .strb(strb), .selStat(selStat), .selCtrl(selCtrl)
  );

  acq_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .selStat(selStat), .selCtrl(selCtrl),
    .busWdata(busWdata), .busRdata(busRdata),
    .convBusy(convBusy), .rangeUni(rangeUni), .muxSingle(muxSingle), .chanNum(chanNum),
    .trigPin(trigPin), .dmaReqIn(dmaReqIn), .dmaReqOut(dmaReqOut), .trigSel(trigSel),
    .irqReq(irqReq), .trigLatch(trigLatch), .trigRise(trigRise), .ctrlQ(ctrlQ)
  );
endmodule

// File: rtl/acq_regs_chk.sv
module acq_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clrTrig,
  input logic       wrCtrl,
  input logic [7:0] busWdata,
  input logic       trigLatch,
  input logic       trigRise,
  input logic [7:0] ctrlQ,
  input logic [7:0] irqReq,
  input logic       dmaReqOut
);
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(irqReq));
  a_r7_low_lines: assert property (@(posedge clk) disable iff (!rstN) irqReq[1:0] == 2'b00);
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq != 8'h00) |-> (trigLatch && ctrlQ[7]));
  a_r9_dma_gate: assert property (@(posedge clk) disable iff (!rstN) !ctrlQ[2] |-> !dmaReqOut);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrTrig && !trigRise) |=> !trigLatch);
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rstN) trigRise |=> trigLatch);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (trigLatch && !clrTrig) |=> trigLatch);
  a_r2_write: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (ctrlQ == ($past(busWdata) & 8'hF7)));
endmodule

bind acq_regs_top acq_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .clrTrig(strb.clrTrig), .wrCtrl(strb.wrCtrl),
  .busWdata(busWdata), .trigLatch(trigLatch), .trigRise(trigRise),
  .ctrlQ(ctrlQ), .irqReq(irqReq), .dmaReqOut(dmaReqOut)
);

// File: tb/test_acq_regs_top.sv
module test_acq_regs_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [3:0] busAddr = 4'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic convBusy = 1'b0, rangeUni = 1'b0, muxSingle = 1'b0;
  logic [3:0] chanNum = 4'd0;
  logic trigPin = 1'b0, dmaReqIn = 1'b0, dmaReqOut;
  logic [1:0] trigSel;
  logic [7:0] irqReq;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  acq_regs_top i_acq_regs_top (.*);

  // {control byte written, expected irqReq}
  localparam logic [15:0] VEC [10] = '{
    {8'h80, 8'h00}, {8'h90, 8'h00}, {8'hA0, 8'h04}, {8'hB0, 8'h08}, {8'hC0, 8'h10},
    {8'hD0, 8'h20}, {8'hE0, 8'h40}, {8'hF0, 8'h80}, {8'h70, 8'h00}, {8'h2F, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); trigPin = 1'b1;
    repeat (n) @(negedge clk);
    trigPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R3 reset state
    busRead(4'd9, rd); check("R3 ctrl", rd, 8'h00);
    busRead(4'd8, rd); check("R3 flag", rd & 8'h10, 8'h00);
    check("R3 irq", irqReq, 8'h00);
    // R1 status layout
    convBusy = 1; rangeUni = 0; muxSingle = 1; chanNum = 4'hA;
    busRead(4'd8, rd); check("R1 pattern A", rd, 8'hAA);
    convBusy = 0; rangeUni = 1; muxSingle = 0; chanNum = 4'h5;
    busRead(4'd8, rd); check("R1 pattern B", rd, 8'h45);
    // R4 short pulse latched and sticky
    pulse(25);
    busRead(4'd8, rd); check("R4 flag", rd, 8'h55);
    repeat (10) @(negedge clk);
    busRead(4'd8, rd); check("R4 sticky", rd & 8'h10, 8'h10);
    // R2 R6 R7 R8 table walk with the flag set
    for (int i = 0; i < 10; i++) begin
      busWrite(4'd9, VEC[i][15:8]);
      busRead(4'd9, rd); check("R2 readback", rd, VEC[i][15:8] & 8'hF7);
      check("R6 R7 R8 routing", irqReq, VEC[i][7:0]);
    end
    check("R2 trigSel", {6'd0, trigSel}, 8'h03);
    // R9 DMA gate (control currently 0x27: dma on)
    dmaReqIn = 1; #1 check("R9 enabled", {7'd0, dmaReqOut}, 8'h01);
    busWrite(4'd9, 8'hE0);
    #1 check("R9 disabled", {7'd0, dmaReqOut}, 8'h00);
    check("R6 level6", irqReq, 8'h40);
    // R12 stray offset
    busWrite(4'd10, 8'h11);
    busRead(4'd9, rd); check("R12 ctrl kept", rd, 8'hE0);
    busRead(4'd10, rd); check("R12 read zero", rd, 8'h00);
    // R5 clear by any write
    busWrite(4'd8, 8'h5A);
    busRead(4'd8, rd); check("R5 cleared", rd & 8'h10, 8'h00);
    check("R5 irq dropped", irqReq, 8'h00);
    // R11 level held through clear
    @(negedge clk); trigPin = 1'b1;
    repeat (6) @(negedge clk);
    busRead(4'd8, rd); check("R11 set by edge", rd & 8'h10, 8'h10);
    busWrite(4'd8, 8'h00);
    repeat (6) @(negedge clk);
    busRead(4'd8, rd); check("R11 no reset from level", rd & 8'h10, 8'h00);
    check("R11 irq", irqReq, 8'h00);
    trigPin = 1'b0;
    repeat (4) @(negedge clk);
    // R10 edge and clear in the same cycle
    @(negedge clk); trigPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'd8; busWdata = 8'hFF;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    busRead(4'd8, rd); check("R10 edge wins", rd & 8'h10, 8'h10);
    check("R10 irq", irqReq, 8'h40);
    trigPin = 1'b0;
    // R3 reset clears again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(4'd9, rd); check("R3 ctrl after reset", rd, 8'h00);
    busRead(4'd8, rd); check("R3 flag after reset", rd & 8'h10, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule